// File: doc/BRIEF.md
# Four-Quadrant Gate Drive Steering

This block sits between the PWM comparator and the three gate drivers of a bidirectional flyback ring generator. It receives one PWM pulse per switching cycle, a phase signal that marks the part of the cycle after the pulse, the polarity of the error signal and the polarity of the reference. From the two polarity bits it works out which of four operating quadrants the converter is in. It then steers the PWM to the switch that has to be modulated, and the post-pulse phase to the secondary switch that has to act as a synchronous rectifier.

Three outputs are driven: the primary switch, a p-channel secondary switch whose drive is active low, and an n-channel secondary switch. The mode and the current-limit flag are captured once per switching cycle, on a cycle-start strobe. While the captured flag is set, the PWM for that cycle is dropped. If the quadrant changes, one cycle passes with every switch held off. A low enable forces all three outputs to their off levels. All outputs come from registers.

Top module: `quad_gate_steer`

## Requirements
- R1: The quadrant is taken as {ref_neg, err_neg}. With 00 (positive reference, forward power), the PWM drives gd_pri and the p-channel switch acts as rectifier.
- R2: With 01 (positive reference, reverse power), the PWM drives gd_nch. gd_pri stays low and no rectifier is driven.
- R3: With 10 (negative reference, forward power), the PWM drives gd_pri and gd_nch acts as rectifier.
- R4: With 11 (negative reference, reverse power), the PWM drives the p-channel switch. gd_pri stays low and no rectifier is driven.
- R5: gd_pch_n is active low: 0 turns the p-channel switch on and 1 turns it off.
- R6: A rectifier output turns on only while rect_phase is 1 and pwm_in is 0. The two secondary switches are never on together.
- R7: If ilim is 1 at a cycle start, the modulated switch stays off for that whole cycle. The rectifier is not affected. PWM returns on the next cycle in which ilim was 0 at the cycle start.
- R8: With enable at 0, gd_pri = 0, gd_pch_n = 1 and gd_nch = 0, one clock later.
- R9: The quadrant and the current-limit flag are captured only on a clock edge where cyc_start is 1. A change of ref_neg, err_neg or ilim in the middle of a cycle has no effect.
- R10: A cycle whose captured quadrant differs from the previous one has no PWM and no rectifier drive.
- R11: During reset the outputs are gd_pri = 0, gd_pch_n = 1 and gd_nch = 0. Until the first cycle start after reset, no switch is driven.
- R12: Each output follows its inputs with a latency of exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | Strobe that marks the first clock of a switching cycle |
| pwm_in | input | 1 | PWM pulse from the comparator |
| rect_phase | input | 1 | High in the part of the cycle after the pulse |
| err_neg | input | 1 | Error polarity, 1 = output above reference |
| ref_neg | input | 1 | Reference polarity, 1 = negative |
| ilim | input | 1 | Cycle-by-cycle current-limit flag |
| enable | input | 1 | Output enable, active high |
| gd_pri | output | 1 | Primary switch drive, active high |
| gd_pch_n | output | 1 | P-channel secondary drive, active low |
| gd_nch | output | 1 | N-channel secondary drive, active high |

## Verification
The bench walks through all four quadrants in the order a sine period visits them. This exposes a design that swaps the two secondaries, drives a rectifier in the reverse-power quadrants, or forgets to invert the p-channel output. It checks the off cycle at each quadrant change, since a design without it would let the old and new secondaries overlap. It also changes the polarity bits in the middle of a cycle, which a design that does not latch the mode would re-steer mid-pulse. Current-limit cycles check both that the pulse is dropped and that it comes back: a sticky blank would leave the converter dead, and a missing blank would pass the pulse through.

// File: rtl/qgs_pkg.sv
package qgs_pkg;
  // Quadrant code is {reference negative, error negative}
  typedef enum logic [1:0] {
    QM_FWD_POS = 2'b00,
    QM_REV_POS = 2'b01,
    QM_FWD_NEG = 2'b10,
    QM_REV_NEG = 2'b11
  } qmode_e;
endpackage

// File: rtl/qgs_cycle_latch.sv
module qgs_cycle_latch
  import qgs_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cyc_start,
  input  logic   ref_neg,
  input  logic   err_neg,
  input  logic   ilim,
  output qmode_e mode_q,
  output logic   guard_q,
  output logic   blank_q
);
  qmode_e mode_d;
  logic   guard_d;
  logic   blank_d;
  qmode_e mode_new;

  always_comb begin
    mode_new = qmode_e'({ref_neg, err_neg});
    mode_d   = mode_q;
    guard_d  = guard_q;
    blank_d  = blank_q;
    if (cyc_start) begin
      mode_d  = mode_new;
      guard_d = (mode_new != mode_q);
      blank_d = ilim;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= QM_FWD_POS;
      guard_q <= 1'b1;
      blank_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      guard_q <= guard_d;
      blank_q <= blank_d;
    end
  end

  // R9: captured state only moves on a cycle start
  a_r9_hold_mid_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_start |=> ($stable(mode_q) && $stable(blank_q)));

  // R10: a new quadrant always opens with the off cycle
  a_r10_guard_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && (qmode_e'({ref_neg, err_neg}) != mode_q)) |=> guard_q);
endmodule

// File: rtl/qgs_route.sv
module qgs_route
  import qgs_pkg::*;
(
  input  qmode_e mode,
  input  logic   guard,
  input  logic   blank,
  input  logic   pwm_in,
  input  logic   rect_phase,
  output logic   pri_on,
  output logic   pch_on,
  output logic   nch_on
);
  logic pwm_act;
  logic rect_act;

  always_comb begin
    pwm_act  = pwm_in & ~blank & ~guard;
    rect_act = rect_phase & ~pwm_in & ~guard;
    pri_on   = 1'b0;
    pch_on   = 1'b0;
    nch_on   = 1'b0;
    unique case (mode)
      QM_FWD_POS: begin
        pri_on = pwm_act;
        pch_on = rect_act;
      end
      QM_REV_POS: nch_on = pwm_act;
      QM_FWD_NEG: begin
        pri_on = pwm_act;
        nch_on = rect_act;
      end
      QM_REV_NEG: pch_on = pwm_act;
      default: ;
    endcase
  end
endmodule

// File: rtl/qgs_drive.sv
module qgs_drive #(
  parameter bit PCH_ACTIVE_LOW = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic pri_on,
  input  logic pch_on,
  input  logic nch_on,
  output logic gd_pri,
  output logic gd_pch,
  output logic gd_nch
);
  localparam logic PCH_OFF = PCH_ACTIVE_LOW;

  logic pri_d, pch_lvl, nch_d;
  logic pri_q, pch_q, nch_q;

  always_comb begin
    pri_d = enable & pri_on;
    nch_d = enable & nch_on;
  end

  generate
    if (PCH_ACTIVE_LOW) begin : g_pch_inv
      always_comb pch_lvl = ~(enable & pch_on);
    end else begin : g_pch_true
      always_comb pch_lvl = enable & pch_on;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_q <= 1'b0;
      pch_q <= PCH_OFF;
      nch_q <= 1'b0;
    end else begin
      pri_q <= pri_d;
      pch_q <= pch_lvl;
      nch_q <= nch_d;
    end
  end

  assign gd_pri = pri_q;
  assign gd_pch = pch_q;
  assign gd_nch = nch_q;

  // R8: disabled cycle leaves every switch off
  a_r8_enable_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!gd_pri && (gd_pch == PCH_OFF) && !gd_nch));

  // R6: the two secondaries never conduct together
  a_r6_no_shoot: assert property (@(posedge clk) disable iff (!rst_n)
    !((gd_pch != PCH_OFF) && gd_nch));
endmodule

// File: rtl/quad_gate_steer.sv
module quad_gate_steer
  import qgs_pkg::*;
#(
  parameter bit PCH_ACTIVE_LOW = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  input  logic pwm_in,
  input  logic rect_phase,
  input  logic err_neg,
  input  logic ref_neg,
  input  logic ilim,
  input  logic enable,
  output logic gd_pri,
  output logic gd_pch_n,
  output logic gd_nch
);
  qmode_e mode_q;
  logic   guard_q, blank_q;
  logic   pri_on, pch_on, nch_on;

  qgs_cycle_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_start (cyc_start),
    .ref_neg   (ref_neg),
    .err_neg   (err_neg),
    .ilim      (ilim),
    .mode_q    (mode_q),
    .guard_q   (guard_q),
    .blank_q   (blank_q)
  );

  qgs_route u_route (
    .mode       (mode_q),
    .guard      (guard_q),
    .blank      (blank_q),
    .pwm_in     (pwm_in),
    .rect_phase (rect_phase),
    .pri_on     (pri_on),
    .pch_on     (pch_on),
    .nch_on     (nch_on)
  );

  qgs_drive #(.PCH_ACTIVE_LOW(PCH_ACTIVE_LOW)) u_drive (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .pri_on (pri_on),
    .pch_on (pch_on),
    .nch_on (nch_on),
    .gd_pri (gd_pri),
    .gd_pch (gd_pch_n),
    .gd_nch (gd_nch)
  );

  // R7: a blanked cycle never turns the primary on
  a_r7_blank_primary: assert property (@(posedge clk) disable iff (!rst_n)
    blank_q |=> !gd_pri);

  // R2 / R4: reverse-power quadrants keep the primary off
  a_r2_rev_primary_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == QM_REV_POS || mode_q == QM_REV_NEG) |=> !gd_pri);
endmodule

// File: tb/quad_gate_steer_tb.sv
module quad_gate_steer_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic cyc_start, pwm_in, rect_phase, err_neg, ref_neg, ilim, enable;
  logic gd_pri, gd_pch_n, gd_nch;
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  quad_gate_steer u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .pwm_in(pwm_in),
    .rect_phase(rect_phase), .err_neg(err_neg), .ref_neg(ref_neg),
    .ilim(ilim), .enable(enable),
    .gd_pri(gd_pri), .gd_pch_n(gd_pch_n), .gd_nch(gd_nch)
  );

  // {ref_neg, err_neg, ilim, enable, pwm, rect, exp_pri, exp_pch_n, exp_nch}
  localparam int NV = 20;
  localparam logic [8:0] VEC [NV] = '{
    9'b00_0_1_10_110, // R1 fwd pos, pwm on primary
    9'b00_0_1_01_000, // R6 rectifier (p-ch low) after pulse
    9'b00_0_1_11_110, // R6 no rectifier while pulse high
    9'b01_0_1_10_010, // R10 change -> off cycle
    9'b01_0_1_10_011, // R2 pwm on n-ch
    9'b01_0_1_01_010, // R2 no rectifier
    9'b10_0_1_01_010, // R10 change -> off cycle
    9'b10_0_1_10_110, // R3 pwm on primary
    9'b10_0_1_01_011, // R3 n-ch rectifies
    9'b11_0_1_10_010, // R10 change -> off cycle
    9'b11_0_1_10_000, // R4 R5 pwm on p-ch, active low
    9'b11_0_1_01_010, // R4 no rectifier
    9'b11_1_1_10_010, // R7 blanked
    9'b11_0_1_10_000, // R7 resumes
    9'b00_0_1_10_010, // R10 change -> off cycle
    9'b00_1_1_10_010, // R7 primary blanked
    9'b00_1_1_01_000, // R7 rectifier unaffected
    9'b00_0_0_10_010, // R8 disabled
    9'b00_0_0_01_010, // R8 disabled
    9'b00_0_1_10_110  // R1 back on
  };
  string VTAG [NV] = '{"R1","R6","R6","R10","R2","R2","R10","R3","R3","R10",
                       "R4","R4","R7","R7","R10","R7","R7","R8","R8","R1"};

  task automatic check(input string tag, input logic [2:0] exp);
    n_chk++;
    if ({gd_pri, gd_pch_n, gd_nch} !== exp) begin
      n_fail++;
      $display("FAIL %s: {pri,pch_n,nch} actual=%b expected=%b", tag,
               {gd_pri, gd_pch_n, gd_nch}, exp);
    end
  endtask

  // One switching cycle: strobe clock with the mode, then a pulse clock (R12: output one clock later)
  task automatic run_cycle(input logic [8:0] v);
    @(negedge clk);
    cyc_start = 1'b1; ref_neg = v[8]; err_neg = v[7]; ilim = v[6];
    enable = v[5]; pwm_in = 1'b0; rect_phase = 1'b0;
    @(negedge clk);
    cyc_start = 1'b0; pwm_in = v[4]; rect_phase = v[3];
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; cyc_start = 0; pwm_in = 0; rect_phase = 0;
    err_neg = 0; ref_neg = 0; ilim = 0; enable = 1;
    repeat (3) @(negedge clk);
    check("R11 reset", 3'b010);
    rst_n = 1'b1;
    // R11: no drive before first cycle start
    pwm_in = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R11 pre-start", 3'b010);
    pwm_in = 1'b0;

    for (int i = 0; i < NV; i++) begin
      run_cycle(VEC[i]);
      check(VTAG[i], VEC[i][2:0]);
    end

    // R9: mode bits flip mid-cycle, routing stays in forward-positive
    run_cycle(9'b00_0_1_10_110);
    check("R9 baseline", 3'b110);
    ref_neg = 1'b1; err_neg = 1'b1; ilim = 1'b1;
    @(negedge clk);
    check("R9 mid-cycle change ignored", 3'b110);
    pwm_in = 1'b0; rect_phase = 1'b1;
    @(negedge clk);
    check("R9 rectifier still p-ch", 3'b000);

    // R12: output changes exactly one clock after input
    @(negedge clk);
    rect_phase = 1'b0; pwm_in = 1'b1;
    @(posedge clk); #1;
    check("R12 one-clock latency", 3'b110);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule